// File: doc/BRIEF.md
# Exception entry and return controller

This block owns the processor status word and the banked saved-status and link registers of the five exception modes. It watches seven exception request lines. When a request is accepted on a clock edge, the block performs the whole entry in that edge. The old status word goes into the target mode's saved-status register. The supplied PC is stored in that mode's link register. The status word switches mode, leaves the 16-bit instruction state and raises the interrupt masks. A one-cycle redirect pulse then carries the vector address out to the fetch logic.

A return strobe reverses the entry. The status word is reloaded from the current mode's saved copy, and a redirect carries that mode's link register. Two things are outside the block: decoding that raises the requests, and the datapath that produces the PC. A small port reads and writes the banked registers directly, and a second port loads the status word, for example after a flag update.

Top module: `excp_ctl`

## Requirements
- R1: While reset is held, and until the first accepted event after it, `sts_o` is 0x000000D3 (supervisor mode, I and F set, T clear) and `pc_load_o` is 0.
- R2: The status word layout is N bit 31, Z bit 30, C bit 29, V bit 28, I bit 7 (1 = IRQ masked), F bit 6 (1 = FIQ masked), T bit 5 (1 = 16-bit state) and mode bits 4:0. The mode codes are user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. With no entry and no valid return, `sts_we_i` loads `sts_wdata_i` into the status word on the clock edge.
- R3: Request bits are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 5 and FIQ 6. Every entry other than reset writes the old status word into the target mode's saved-status register and writes `pc_i` into its link register. The target modes are undefined→undefined, software interrupt→supervisor, both aborts→abort, IRQ→IRQ and FIQ→FIQ.
- R4: After any entry, the status word holds the target mode, T=0 and I=1. F becomes 1 for reset and FIQ entries and is unchanged for the others. Bits 31:8 are unchanged.
- R5: In the cycle after an entry edge, `pc_load_o` is 1 and `pc_tgt_o` holds the vector. The vectors are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C.
- R6: When several requests are eligible, exactly one is taken, in the order reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R7: An IRQ request is ignored while I=1, and an FIQ request is ignored while F=1. The status word and redirect are unaffected by the ignored request.
- R8: A reset request enters supervisor mode and writes no banked register.
- R9: When `eret_i` is high in a banked mode, the next cycle's status word equals that mode's saved-status register, and `pc_load_o`=1 with `pc_tgt_o` equal to its link register.
- R10: `eret_i` is ignored in user, system or any unlisted mode.
- R11: An exception accepted in the same cycle as `eret_i` takes effect, and the return is dropped.
- R12: In the test address `tp_addr_i`, bit 3 selects the saved-status register (1) or the link register (0). Bits 2:0 select the bank: FIQ 0, IRQ 1, supervisor 2, abort 3, undefined 4. Reads are combinational. Writes take effect on the clock edge. Banks 5 to 7 read 0 and ignore writes. An entry writing the same register in the same cycle wins over the test write.
- R13: A status-word load via `sts_we_i` is dropped when an entry or a valid return occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_req_i | input | 7 | Exception request lines, bit order per R3 |
| pc_i | input | 32 | Return address stored on entry |
| sts_we_i | input | 1 | Load status word |
| sts_wdata_i | input | 32 | Status word to load |
| eret_i | input | 1 | Return-from-exception strobe |
| tp_addr_i | input | 4 | Test port register select |
| tp_we_i | input | 1 | Test port write enable |
| tp_wdata_i | input | 32 | Test port write data |
| sts_o | output | 32 | Current status word |
| pc_load_o | output | 1 | One-cycle PC redirect pulse |
| pc_tgt_o | output | 32 | Redirect address, valid with pc_load_o |
| tp_rdata_o | output | 32 | Test port read data |

## Verification
An accepted exception and a return strobe can land on the same edge, and so can an entry and a test-port write to the register that entry saves. Directed steps raise an IRQ together with the return strobe, and a test write to the IRQ link register together with an IRQ. The random phase keeps producing such overlaps. The outcome is judged against a bench model in which the entry wins: the redirect must be the vector and not a link register, and a test-port readback must show the saved PC and not the test data.

// File: rtl/excp_pkg.sv
package excp_pkg;
  localparam int XLEN   = 32;
  localparam int NREQ   = 7;
  localparam int NBANK  = 5;
  localparam int BANK_W = 3;
  localparam int MODE_W = 5;
  localparam int ST_I   = 7;
  localparam int ST_F   = 6;
  localparam int ST_T   = 5;

  typedef logic [2:0] exc_idx_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam exc_idx_t EX_RST  = 3'd0;
  localparam exc_idx_t EX_UND  = 3'd1;
  localparam exc_idx_t EX_SWI  = 3'd2;
  localparam exc_idx_t EX_PABT = 3'd3;
  localparam exc_idx_t EX_DABT = 3'd4;
  localparam exc_idx_t EX_IRQ  = 3'd5;
  localparam exc_idx_t EX_FIQ  = 3'd6;

  localparam mode_t MD_USR = 5'b10000;
  localparam mode_t MD_FIQ = 5'b10001;
  localparam mode_t MD_IRQ = 5'b10010;
  localparam mode_t MD_SVC = 5'b10011;
  localparam mode_t MD_ABT = 5'b10111;
  localparam mode_t MD_UND = 5'b11011;
  localparam mode_t MD_SYS = 5'b11111;

  localparam bank_t NO_BANK  = 3'd7;
  localparam bank_t BANK_LIM = BANK_W'(NBANK);
  localparam logic [XLEN-1:0] STS_RESET = 32'h0000_00D3;

  function automatic mode_t target_mode(exc_idx_t e);
    case (e)
      EX_UND:           return MD_UND;
      EX_PABT, EX_DABT: return MD_ABT;
      EX_IRQ:           return MD_IRQ;
      EX_FIQ:           return MD_FIQ;
      default:          return MD_SVC;
    endcase
  endfunction

  // vectors step by 4, with one slot skipped before IRQ
  function automatic logic [XLEN-1:0] vector_of(exc_idx_t e);
    logic [XLEN-1:0] slot;
    slot = XLEN'(e) + ((e >= EX_IRQ) ? XLEN'(1) : XLEN'(0));
    return slot << 2;
  endfunction

  function automatic bank_t bank_of(mode_t m);
    case (m)
      MD_FIQ:  return 3'd0;
      MD_IRQ:  return 3'd1;
      MD_SVC:  return 3'd2;
      MD_ABT:  return 3'd3;
      MD_UND:  return 3'd4;
      default: return NO_BANK;
    endcase
  endfunction

  // rank 0 is the most urgent
  function automatic exc_idx_t rank_to_exc(int r);
    case (r)
      0:       return EX_RST;
      1:       return EX_DABT;
      2:       return EX_FIQ;
      3:       return EX_IRQ;
      4:       return EX_PABT;
      5:       return EX_UND;
      default: return EX_SWI;
    endcase
  endfunction
endpackage

// File: rtl/excp_arb.sv
module excp_arb
  import excp_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic [N-1:0] req,
  input  logic         irq_masked,
  input  logic         fiq_masked,
  output logic         taken,
  output exc_idx_t     sel
);
  logic [N-1:0] elig;

  always_comb begin
    elig = req;
    if (irq_masked) elig[EX_IRQ] = 1'b0;
    if (fiq_masked) elig[EX_FIQ] = 1'b0;
  end

  // scan from least to most urgent so the most urgent eligible line is kept
  always_comb begin
    taken = 1'b0;
    sel   = EX_RST;
    for (int r = N - 1; r >= 0; r--) begin
      if (elig[rank_to_exc(r)]) begin
        taken = 1'b1;
        sel   = rank_to_exc(r);
      end
    end
  end
endmodule

// File: rtl/excp_bank.sv
module excp_bank
  import excp_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int NB = NBANK
) (
  input  logic         clk,
  input  logic         ent_we,
  input  bank_t        ent_bank,
  input  logic [W-1:0] ent_spsr,
  input  logic [W-1:0] ent_lr,
  input  logic         tp_we,
  input  logic         tp_kind,
  input  bank_t        tp_bank,
  input  logic [W-1:0] tp_wdata,
  input  bank_t        ret_bank,
  output logic [W-1:0] ret_spsr,
  output logic [W-1:0] ret_lr,
  output logic [W-1:0] tp_rdata
);
  logic [W-1:0] spsr_all [NB];
  logic [W-1:0] lr_all   [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic         ent_hit, tp_hit;
    logic         spsr_en, lr_en;
    logic [W-1:0] spsr_d, lr_d, spsr_q, lr_q;

    assign ent_hit = ent_we && (ent_bank == BANK_W'(g));
    assign tp_hit  = tp_we  && (tp_bank  == BANK_W'(g));

    always_comb begin
      spsr_en = ent_hit || (tp_hit && tp_kind);
      lr_en   = ent_hit || (tp_hit && !tp_kind);
      spsr_d  = ent_hit ? ent_spsr : tp_wdata;
      lr_d    = ent_hit ? ent_lr   : tp_wdata;
    end

    always_ff @(posedge clk) begin
      if (spsr_en) spsr_q <= spsr_d;
      if (lr_en)   lr_q   <= lr_d;
    end

    assign spsr_all[g] = spsr_q;
    assign lr_all[g]   = lr_q;
  end

  always_comb begin
    ret_spsr = '0;
    ret_lr   = '0;
    tp_rdata = '0;
    if (ret_bank < BANK_LIM) begin
      ret_spsr = spsr_all[ret_bank];
      ret_lr   = lr_all[ret_bank];
    end
    if (tp_bank < BANK_LIM) tp_rdata = tp_kind ? spsr_all[tp_bank] : lr_all[tp_bank];
  end
endmodule

// File: rtl/excp_ctl.sv
module excp_ctl
  import excp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] exc_req_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            sts_we_i,
  input  logic [XLEN-1:0] sts_wdata_i,
  input  logic            eret_i,
  input  logic [3:0]      tp_addr_i,
  input  logic            tp_we_i,
  input  logic [XLEN-1:0] tp_wdata_i,
  output logic [XLEN-1:0] sts_o,
  output logic            pc_load_o,
  output logic [XLEN-1:0] pc_tgt_o,
  output logic [XLEN-1:0] tp_rdata_o
);
  logic            rst_s1, rst_q;
  logic [XLEN-1:0] sts_q, sts_d;
  logic            sts_en;
  logic            pc_load_q, pc_load_d;
  logic [XLEN-1:0] pc_tgt_q, pc_d;
  logic            taken;
  exc_idx_t        sel;
  mode_t           ent_mode;
  bank_t           ent_bank, cur_bank;
  logic            ent_we, ret_ok;
  logic [XLEN-1:0] ret_spsr, ret_lr;

  // reset asserts at once, leaves two edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  excp_arb #(.N(NREQ)) u_arb (
    .req        (exc_req_i),
    .irq_masked (sts_q[ST_I]),
    .fiq_masked (sts_q[ST_F]),
    .taken      (taken),
    .sel        (sel)
  );

  always_comb begin
    ent_mode = target_mode(sel);
    ent_bank = bank_of(ent_mode);
    ent_we   = taken && (sel != EX_RST);
    cur_bank = bank_of(sts_q[MODE_W-1:0]);
    ret_ok   = eret_i && !taken && (cur_bank != NO_BANK);
  end

  excp_bank #(.W(XLEN), .NB(NBANK)) u_bank (
    .clk      (clk),
    .ent_we   (ent_we),
    .ent_bank (ent_bank),
    .ent_spsr (sts_q),
    .ent_lr   (pc_i),
    .tp_we    (tp_we_i),
    .tp_kind  (tp_addr_i[3]),
    .tp_bank  (tp_addr_i[2:0]),
    .tp_wdata (tp_wdata_i),
    .ret_bank (cur_bank),
    .ret_spsr (ret_spsr),
    .ret_lr   (ret_lr),
    .tp_rdata (tp_rdata_o)
  );

  // next state of status word and redirect
  always_comb begin
    sts_d     = sts_q;
    sts_en    = 1'b0;
    pc_load_d = 1'b0;
    pc_d      = ret_lr;
    if (taken) begin
      sts_en               = 1'b1;
      sts_d[MODE_W-1:0]    = ent_mode;
      sts_d[ST_T]          = 1'b0;
      sts_d[ST_I]          = 1'b1;
      if (sel == EX_RST || sel == EX_FIQ) sts_d[ST_F] = 1'b1;
      pc_load_d            = 1'b1;
      pc_d                 = vector_of(sel);
    end else if (ret_ok) begin
      sts_en    = 1'b1;
      sts_d     = ret_spsr;
      pc_load_d = 1'b1;
    end else if (sts_we_i) begin
      sts_en = 1'b1;
      sts_d  = sts_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sts_q     <= STS_RESET;
      pc_load_q <= 1'b0;
      pc_tgt_q  <= '0;
    end else begin
      if (sts_en)    sts_q    <= sts_d;
      pc_load_q <= pc_load_d;
      if (pc_load_d) pc_tgt_q <= pc_d;
    end
  end

  assign sts_o     = sts_q;
  assign pc_load_o = pc_load_q;
  assign pc_tgt_o  = pc_tgt_q;
endmodule

// File: rtl/excp_chk.sv
module excp_chk
  import excp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] exc_req,
  input logic            eret,
  input logic            sts_we,
  input logic            taken,
  input logic [XLEN-1:0] sts_o,
  input logic            pc_load_o,
  input logic [XLEN-1:0] pc_tgt_o
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R8
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(exc_req[EX_RST]) |->
      pc_load_o && (pc_tgt_o == '0) && (sts_o[MODE_W-1:0] == MD_SVC) && (sts_o[7:5] == 3'b110));

  // R4
  entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(taken) |-> pc_load_o && sts_o[ST_I] && !sts_o[ST_T]);

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(exc_req == 7'b0100000 && sts_o[ST_I] && !eret) |-> !pc_load_o);

  // R10
  ret_unbanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(exc_req == '0 && eret &&
      (sts_o[MODE_W-1:0] == MD_USR || sts_o[MODE_W-1:0] == MD_SYS)) |-> !pc_load_o);

  // R2
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!taken && !eret && !sts_we) |-> $stable(sts_o));
endmodule

bind excp_ctl excp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .exc_req   (exc_req_i),
  .eret      (eret_i),
  .sts_we    (sts_we_i),
  .taken     (taken),
  .sts_o     (sts_o),
  .pc_load_o (pc_load_o),
  .pc_tgt_o  (pc_tgt_o)
);

// File: tb/sim_excp_ctl.sv
module sim_excp_ctl;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  exc_req;
  logic [31:0] pc, sts_wd, tp_wd;
  logic        sts_we, eret, tp_we;
  logic [3:0]  tp_addr;
  logic [31:0] sts_o, pc_tgt_o, tp_rdata_o;
  logic        pc_load_o;

  int tests = 0;
  int fails = 0;

  logic [31:0] m_sts;
  logic [31:0] m_spsr [5];
  logic [31:0] m_lr   [5];
  logic        m_load;
  logic [31:0] m_tgt;

  always #(CLK_NS/2) clk = ~clk;

  excp_ctl u0 (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .pc_i(pc),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd), .eret_i(eret),
    .tp_addr_i(tp_addr), .tp_we_i(tp_we), .tp_wdata_i(tp_wd),
    .sts_o(sts_o), .pc_load_o(pc_load_o), .pc_tgt_o(pc_tgt_o), .tp_rdata_o(tp_rdata_o)
  );

  function automatic int bank_m(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [4:0] mode_m(int e);
    case (e)
      1:       return 5'b11011;
      3, 4:    return 5'b10111;
      5:       return 5'b10010;
      6:       return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] vec_m(int e);
    case (e)
      0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
      4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] rq, input logic [31:0] p, input logic swe,
                      input logic [31:0] swd, input logic er, input logic [3:0] ta,
                      input logic twe, input logic [31:0] twd, input string tag_in);
    int ord [7] = '{0, 4, 6, 5, 3, 1, 2};
    logic [6:0] el;
    int s, cb, b, tb;
    logic [31:0] rs, rl;
    string tag;
    exc_req = rq; pc = p; sts_we = swe; sts_wd = swd; eret = er;
    tp_addr = ta; tp_we = twe; tp_wd = twd;
    el = rq;
    if (m_sts[7]) el[5] = 1'b0;
    if (m_sts[6]) el[6] = 1'b0;
    s = -1;
    for (int k = 0; k < 7; k++) if (s < 0 && el[ord[k]]) s = ord[k];
    cb = bank_m(m_sts[4:0]);
    rs = (cb >= 0) ? m_spsr[cb] : 32'h0;
    rl = (cb >= 0) ? m_lr[cb] : 32'h0;
    tb = int'(ta[2:0]);
    if (twe && tb < 5) begin
      if (ta[3]) m_spsr[tb] = twd; else m_lr[tb] = twd;
    end
    m_load = 1'b0;
    if (s >= 0) begin
      b = bank_m(mode_m(s));
      if (s != 0) begin m_spsr[b] = m_sts; m_lr[b] = p; end
      m_sts[4:0] = mode_m(s); m_sts[5] = 1'b0; m_sts[7] = 1'b1;
      if (s == 0 || s == 6) m_sts[6] = 1'b1;
      m_load = 1'b1; m_tgt = vec_m(s);
    end else if (er && cb >= 0) begin
      m_sts = rs; m_load = 1'b1; m_tgt = rl;
    end else if (swe) begin
      m_sts = swd;
    end
    if (tag_in != "") tag = tag_in;
    else if (s == 0) tag = "R8";
    else if (s >= 0 && er) tag = "R11";
    else if (s >= 0) tag = "R4";
    else if (rq != 7'd0) tag = "R7";
    else if (er && cb < 0) tag = "R10";
    else if (er) tag = "R9";
    else if (swe) tag = "R13";
    else tag = "R12";
    @(posedge clk); #1;
    chk(tag, "sts_o", sts_o, m_sts);
    chk(tag, "pc_load_o", {31'd0, pc_load_o}, {31'd0, m_load});
    if (m_load) chk(tag, "pc_tgt_o", pc_tgt_o, m_tgt);
    @(negedge clk);
    exc_req = '0; sts_we = 1'b0; eret = 1'b0; tp_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    logic [31:0] e;
    tp_addr = a; tp_we = 1'b0;
    #1;
    if (a[2:0] >= 3'd5) e = 32'h0;
    else e = a[3] ? m_spsr[int'(a[2:0])] : m_lr[int'(a[2:0])];
    chk(tag, "tp_rdata_o", tp_rdata_o, e);
  endtask

  task automatic idle(input string tag);
    step(7'd0, 32'h0, 1'b0, 32'h0, 1'b0, 4'h0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [4:0] mtab [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111, 5'b00101};
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; exc_req = '0; pc = '0; sts_we = 0; sts_wd = '0; eret = 0;
    tp_addr = '0; tp_we = 0; tp_wd = '0;
    m_sts = 32'h0000_00D3; m_load = 0; m_tgt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sts_o in reset", sts_o, 32'h0000_00D3);
    chk("R1", "pc_load_o in reset", {31'd0, pc_load_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "sts_o after release", sts_o, 32'h0000_00D3);
    // R12: preload every banked register via the test port
    for (int i = 0; i < 5; i++) begin
      step(7'd0, 0, 0, 0, 0, {1'b0, 3'(i)}, 1'b1, 32'h1000_0000 + 32'(i), "R12");
      step(7'd0, 0, 0, 0, 0, {1'b1, 3'(i)}, 1'b1, 32'h2000_0000 + 32'(i), "R12");
    end
    for (int a = 0; a < 16; a++) rd(4'(a), "R12");
    step(7'd0, 0, 0, 0, 0, 4'b1101, 1'b1, 32'hDEAD_BEEF, "R12");
    rd(4'b1101, "R12");
    // R2: load user mode status with flags
    step(7'd0, 0, 1'b1, 32'hA000_0010, 0, 4'h0, 0, 0, "R2");
    // R7: IRQ ignored while I=1
    step(7'd0, 0, 1'b1, 32'h5000_00B0, 0, 4'h0, 0, 0, "R2");
    step(7'b0100000, 32'h44, 0, 0, 0, 4'h0, 0, 0, "R7");
    step(7'd0, 0, 1'b1, 32'hA000_0030, 0, 4'h0, 0, 0, "R2");
    // R3 R4 R5: IRQ entry from 16-bit user state
    step(7'b0100000, 32'h0000_0100, 0, 0, 0, 4'h0, 0, 0, "R5");
    rd(4'b1001, "R3"); rd(4'b0001, "R3");
    // R9: return to user
    step(7'd0, 0, 0, 0, 1'b1, 4'h0, 0, 0, "R9");
    // R10: return from user is ignored
    step(7'd0, 0, 0, 0, 1'b1, 4'h0, 0, 0, "R10");
    step(7'd0, 0, 1'b1, 32'h0000_001F, 0, 4'h0, 0, 0, "R2");
    step(7'd0, 0, 0, 0, 1'b1, 4'h0, 0, 0, "R10");
    // R6: everything but reset at once: data abort first
    step(7'b1111110, 32'h200, 0, 0, 0, 4'h0, 0, 0, "R6");
    // R6: FIQ beats IRQ, prefetch abort, undefined
    step(7'b1101010, 32'h204, 0, 0, 0, 4'h0, 0, 0, "R6");
    // R7: FIQ ignored while F=1
    step(7'b1000000, 32'h208, 0, 0, 0, 4'h0, 0, 0, "R7");
    // R6: prefetch abort beats undefined, then undefined beats swi
    step(7'b0001010, 32'h20C, 0, 0, 0, 4'h0, 0, 0, "R6");
    step(7'b0000110, 32'h210, 0, 0, 0, 4'h0, 0, 0, "R6");
    step(7'b0000100, 32'h214, 0, 0, 0, 4'h0, 0, 0, "R3");
    rd(4'b1010, "R3"); rd(4'b0010, "R3");
    // R13: status load dropped under return
    step(7'd0, 0, 1'b1, 32'h0000_0010, 1'b1, 4'h0, 0, 0, "R13");
    // R11: IRQ with return, entry wins
    step(7'd0, 0, 1'b1, 32'h0000_0013, 0, 4'h0, 0, 0, "R2");
    step(7'b0100000, 32'h300, 0, 0, 1'b1, 4'h0, 0, 0, "R11");
    // R12: entry beats a test write to the same link register
    step(7'd0, 0, 1'b1, 32'h0000_0013, 0, 4'h0, 0, 0, "R2");
    step(7'b0100000, 32'h400, 0, 0, 0, 4'b0001, 1'b1, 32'h5555_5555, "R12");
    rd(4'b0001, "R12");
    // R8: reset request leaves supervisor bank untouched
    step(7'b1111111, 32'h500, 0, 0, 1'b1, 4'h0, 0, 0, "R8");
    rd(4'b0010, "R8"); rd(4'b1010, "R8");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] rq;
      logic [31:0] swd;
      rq = 7'd0;
      if ($urandom_range(3) == 0) begin
        rq = 7'($urandom_range(127)) & ~7'd1;
        if ($urandom_range(1) == 0) rq = 7'd1 << $urandom_range(6, 1);
        if ($urandom_range(15) == 0) rq[0] = 1'b1;
      end
      swd = $urandom;
      swd[4:0] = mtab[$urandom_range(7)];
      step(rq, $urandom, ($urandom_range(5) == 0), swd, ($urandom_range(5) == 0),
           4'($urandom_range(15)), ($urandom_range(7) == 0), $urandom, "");
      if (n % 16 == 0) for (int a = 0; a < 16; a++) rd(4'(a), "R12");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule